// File: doc/BRIEF.md
# Burst Beat Planner

This block turns one memory-mapped burst request into the sequence of per-beat transfer descriptors a data mover needs. A request carries a start byte address, a length code, a beat-size code and a burst-kind code. It is accepted on a valid/ready handshake. The block then streams one descriptor per beat on a second valid/ready interface. Each descriptor holds the beat's byte address, the byte lanes of the data bus that the beat occupies, and a flag on the final beat.

It handles repeating-address, incrementing and wrapping bursts. It also handles beats narrower than the bus, whose active lanes move across the bus from beat to beat, and an unaligned incrementing start, where the first beat is partial and every later beat is size-aligned. Requests that the protocol forbids are not expanded. They are answered with a one-cycle error pulse and produce no beats. The data bus width is a parameter from 32 to 128 bits.

Top module: `burst_beat_planner`

## Requirements
- R1: An accepted legal request produces exactly length code + 1 beats. `beat_last` is high on the final beat only, and `beat_valid` falls after that beat is taken.
- R2: Burst code 2'b00 (repeat) gives every beat the start address and the same lane mask.
- R3: Burst code 2'b01 (increment) gives the start address on beat 0. Beat i > 0 gets the start address rounded down to the beat size, plus i times the beat size. For 4-byte beats from address 7, the beats are at 7, 8, 0xC, 0x10 and 0x14.
- R4: Burst code 2'b10 (wrap) steps by the beat size inside a window of (beats × size) bytes, aligned to that total. When a step reaches the top of the window, the next address is the window base.
- R5: The beat size is 2^size-code bytes. Bit k of `beat_strb` is set when k lies between the beat's address modulo the lane count and the next beat-size boundary, excluding that boundary.
- R6: Burst code 2'b11, or a beat size wider than the data bus, gives `req_err` high for one cycle and no beats.
- R7: A wrap request whose length code is not 1, 3, 7 or 15, or whose start address is not aligned to the beat size, is flagged like R6.
- R8: An increment request whose last beat would fall in a different 4096-byte page than its rounded-down start address is flagged like R6.
- R9: `req_ready` is high exactly when no burst is in progress. A beat offered while `beat_ready` is low stays unchanged until it is taken.
- R10: After reset, `req_ready` is high and `beat_valid` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | Burst kind: 00 repeat, 01 increment, 10 wrap, 11 reserved |
| req_err | output | 1 | One-cycle pulse: last accepted request was illegal |
| beat_valid | output | 1 | Beat descriptor offered |
| beat_ready | input | 1 | Beat descriptor taken when high together with beat_valid |
| beat_addr | output | ADDR_W | Byte address of the beat |
| beat_strb | output | DATA_W/8 | Active byte lanes of the beat |
| beat_last | output | 1 | Final beat of the burst |

## Verification
A request taken at a rising edge shows its result in the cycle that follows that edge. This is either the first beat descriptor or the error pulse, and the pulse is gone one cycle later. Each taken beat is replaced by the next descriptor after the same edge. The bench drives and samples only on falling edges. It moves its expected beat index forward only after an edge where it held `beat_ready` high, so stalled beats are checked again against the same expected values. Expected addresses and masks come from modulo arithmetic over whole sweeps of kind, size, length and start address, which is a different formulation from the design's compare-and-reload logic.

// File: rtl/bbp_pkg.sv
// Shared types and constants for the burst beat planner.
package bbp_pkg;
    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    localparam int PAGE_BITS = 12;   // 4096-byte page
    localparam int LEN_W     = 8;
    localparam int SIZE_W    = 3;
endpackage

// File: rtl/bbp_req_check.sv
// Legality check of a burst request (combinational).
// Assumes: only the page offset of the start address is needed; LANE_BITS = log2(bus bytes).
module bbp_req_check
    import bbp_pkg::*;
#(
    parameter int LANE_BITS = 2
) (
    input  logic [PAGE_BITS-1:0] addr_lo,
    input  logic [LEN_W-1:0]     len,
    input  logic [SIZE_W-1:0]    size,
    input  burst_e               burst,
    output logic                 illegal
);
    localparam int OFF_W = 16;

    logic [PAGE_BITS-1:0] nb;
    logic [PAGE_BITS-1:0] aligned;
    logic [OFF_W-1:0]     last_off;
    logic                 size_bad;
    logic                 wrap_bad;
    logic                 page_cross;

    // Derive each illegal condition, then merge them by burst kind.
    always_comb begin
        nb         = PAGE_BITS'(1) << size;
        aligned    = addr_lo & ~(nb - PAGE_BITS'(1));
        last_off   = OFF_W'(aligned) + (OFF_W'(len) << size);
        size_bad   = size > SIZE_W'(LANE_BITS);
        wrap_bad   = !(len == 8'd1 || len == 8'd3 || len == 8'd7 || len == 8'd15)
                     || ((addr_lo & (nb - PAGE_BITS'(1))) != '0);
        page_cross = |last_off[OFF_W-1:PAGE_BITS];
        unique case (burst)
            BURST_FIXED: illegal = size_bad;
            BURST_INCR:  illegal = size_bad || page_cross;
            BURST_WRAP:  illegal = size_bad || wrap_bad;
            default:     illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bbp_next_addr.sv
// Address of the beat that follows the current one (combinational).
// Assumes: a wrap burst is legal (length 2/4/8/16 beats, aligned start).
module bbp_next_addr
    import bbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  burst_e            burst,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] nb;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] total;
    logic [ADDR_W-1:0] win_lo;
    logic [2:0]        wrap_shift;

    // Step to the next size boundary, then fold into the wrap window if needed.
    always_comb begin
        nb       = ADDR_W'(1) << size;
        stepped  = (cur & ~(nb - ADDR_W'(1))) + nb;
        unique case (len)
            8'd1:    wrap_shift = 3'd1;
            8'd3:    wrap_shift = 3'd2;
            8'd7:    wrap_shift = 3'd3;
            default: wrap_shift = 3'd4;
        endcase
        total    = nb << wrap_shift;
        win_lo   = cur & ~(total - ADDR_W'(1));
        unique case (burst)
            BURST_FIXED: nxt = cur;
            BURST_WRAP:  nxt = (stepped == win_lo + total) ? win_lo : stepped;
            default:     nxt = stepped;
        endcase
    end
endmodule

// File: rtl/bbp_lane_mask.sv
// Byte-lane mask of one beat from its low address bits and beat size.
// Assumes: size does not exceed LANE_BITS (guaranteed by the request check).
module bbp_lane_mask
    import bbp_pkg::*;
#(
    parameter int STRB_W    = 4,
    parameter int LANE_BITS = 2
) (
    input  logic [LANE_BITS-1:0] addr_lo,
    input  logic [SIZE_W-1:0]    size,
    output logic [STRB_W-1:0]    strb
);
    localparam int LW = LANE_BITS + 1;

    logic [LW-1:0] nb;
    logic [LW-1:0] first;
    logic [LW-1:0] limit;

    // Span of lanes: from the address lane up to the next size boundary.
    always_comb begin
        nb    = LW'(1) << size;
        first = {1'b0, addr_lo};
        limit = (first & ~(nb - LW'(1))) + nb;
    end

    for (genvar k = 0; k < STRB_W; k++) begin : g_lane
        assign strb[k] = (LW'(k) >= first) && (LW'(k) < limit);
    end
endmodule

// File: rtl/burst_beat_planner.sv
// Expands one burst request into per-beat address / lane-mask descriptors.
// Assumes: DATA_W is 32, 64 or 128; ADDR_W >= 12; one burst in flight at a time.
module burst_beat_planner
    import bbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [1:0]          req_burst,
    output logic                req_err,
    output logic                beat_valid,
    input  logic                beat_ready,
    output logic [ADDR_W-1:0]   beat_addr,
    output logic [DATA_W/8-1:0] beat_strb,
    output logic                beat_last
);
    localparam int STRB_W    = DATA_W / 8;
    localparam int LANE_BITS = $clog2(STRB_W);

    logic              busy_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [SIZE_W-1:0] size_q;
    burst_e            burst_q;
    burst_e            burst_in;
    logic              illegal;
    logic              req_fire;
    logic              beat_fire;
    logic [ADDR_W-1:0] addr_nxt;

    assign burst_in  = burst_e'(req_burst);
    assign req_ready = !busy_q;
    assign req_fire  = req_valid && req_ready;
    assign beat_fire = beat_valid && beat_ready;

    bbp_req_check #(.LANE_BITS(LANE_BITS)) u_check (
        .addr_lo (req_addr[PAGE_BITS-1:0]),
        .len     (req_len),
        .size    (req_size),
        .burst   (burst_in),
        .illegal (illegal)
    );

    bbp_next_addr #(.ADDR_W(ADDR_W)) u_step (
        .cur   (addr_q),
        .len   (len_q),
        .size  (size_q),
        .burst (burst_q),
        .nxt   (addr_nxt)
    );

    bbp_lane_mask #(.STRB_W(STRB_W), .LANE_BITS(LANE_BITS)) u_mask (
        .addr_lo (addr_q[LANE_BITS-1:0]),
        .size    (size_q),
        .strb    (beat_strb)
    );

    // Busy flag: set by a legal request, cleared when the final beat is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                           busy_q <= 1'b0;
        else if (req_fire && !illegal)        busy_q <= 1'b1;
        else if (beat_fire && beat_last)      busy_q <= 1'b0;
    end

    // Error pulse: one cycle after an illegal request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= req_fire && illegal;
    end

    // Burst parameters: captured from a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            size_q  <= '0;
            burst_q <= BURST_FIXED;
        end else if (req_fire && !illegal) begin
            len_q   <= req_len;
            size_q  <= req_size;
            burst_q <= burst_in;
        end
    end

    // Beat address and index: loaded on a request, advanced on each taken beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (req_fire && !illegal) begin
            addr_q <= req_addr;
            cnt_q  <= '0;
        end else if (beat_fire && !beat_last) begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q + LEN_W'(1);
        end
    end

    assign req_err    = err_q;
    assign beat_valid = busy_q;
    assign beat_addr  = addr_q;
    assign beat_last  = busy_q && (cnt_q == len_q);
endmodule

// File: rtl/bbp_checker.sv
// Protocol properties of the burst beat planner, bound to the top module.
// Assumes: connected to the top module's ports and its captured burst kind.
module bbp_checker #(
    parameter int ADDR_W = 32,
    parameter int STRB_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_err,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [STRB_W-1:0] beat_strb,
    input logic              beat_last,
    input logic [1:0]        burst_q
);
    // R9: a stalled beat keeps its descriptor.
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
                                      && $stable(beat_strb) && $stable(beat_last));

    // R9: no new request while beats are being offered.
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && beat_valid));

    // R1: taking the final beat ends the stream.
    a_r1_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && beat_last |=> !beat_valid);

    // R6: an error pulse never comes with a beat.
    a_r6_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !beat_valid);

    // R5: every offered beat occupies at least one lane.
    a_r5_strb_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> beat_strb != '0);

    // R2: a repeating burst keeps address and mask from beat to beat.
    a_r2_fixed_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && burst_q == 2'b00
        |=> beat_addr == $past(beat_addr) && beat_strb == $past(beat_strb));
endmodule

bind burst_beat_planner bbp_checker #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_bbp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_strb  (beat_strb),
    .beat_last  (beat_last),
    .burst_q    (burst_q)
);

// File: tb/burst_beat_planner_tb.sv
// Sweep bench: all burst kinds and sizes over chosen lengths and start addresses.
module burst_beat_planner_tb;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_len = '0;
    logic [2:0]        req_size = '0;
    logic [1:0]        req_burst = '0;
    logic              req_err;
    logic              beat_valid;
    logic              beat_ready = 1'b0;
    logic [ADDR_W-1:0] beat_addr;
    logic [STRB_W-1:0] beat_strb;
    logic              beat_last;

    int checks = 0;
    int errors = 0;
    int stall  = 0;

    always #5 clk = ~clk;

    burst_beat_planner #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
        .req_err(req_err), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(logic [31:0] a, int len, int size, int burst, int i);
        int nb = 1 << size;
        int tot;
        logic [31:0] lo;
        case (burst)
            0: return a;
            1: return (i == 0) ? a : (a & ~32'(nb - 1)) + 32'(i * nb);
            default: begin
                tot = nb * (len + 1);
                lo  = a & ~32'(tot - 1);
                return lo + 32'((int'(a - lo) + i * nb) % tot);
            end
        endcase
    endfunction

    function automatic logic [STRB_W-1:0] exp_strb(logic [31:0] a, int size);
        int nb = 1 << size;
        int lo = int'(a % STRB_W);
        int al = lo & ~(nb - 1);
        logic [STRB_W-1:0] m = '0;
        for (int k = 0; k < STRB_W; k++) m[k] = (k >= lo) && (k < al + nb);
        return m;
    endfunction

    function automatic bit exp_bad(logic [31:0] a, int len, int size, int burst);
        int nb = 1 << size;
        if (burst == 3 || size > 2) return 1'b1;
        if (burst == 2)
            return !(len == 1 || len == 3 || len == 7 || len == 15) || (a % nb) != 0;
        if (burst == 1)
            return int'((a & ~32'(nb - 1)) & 32'hFFF) + len * nb >= 4096;
        return 1'b0;
    endfunction

    task automatic run_req(input logic [31:0] a, input int len, input int size, input int burst);
        string atag;
        string etag;
        int i;
        bit rdy;
        bit bad = exp_bad(a, len, size, burst);
        atag = (burst == 0) ? "R2" : (burst == 1) ? "R3" : "R4";
        etag = (burst == 3 || size > 2) ? "R6" : (burst == 2) ? "R7" : "R8";
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_len = 8'(len);
        req_size = 3'(size); req_burst = 2'(burst);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            chk(req_err == 1'b1, etag, req_err, 1);
            chk(beat_valid == 1'b0, etag, beat_valid, 0);
            @(negedge clk);
            chk(req_err == 1'b0 && beat_valid == 1'b0, etag, {req_err, beat_valid}, 0);
        end else begin
            chk(req_err == 1'b0, "R6 no error on legal", req_err, 0);
            i = 0;
            while (i <= len) begin
                rdy = (stall % 3) != 2;
                stall++;
                beat_ready = rdy;
                chk(beat_valid == 1'b1, "R1 beat present", beat_valid, 1);
                chk(req_ready == 1'b0, "R9 busy", req_ready, 0);
                chk(beat_addr == exp_addr(a, len, size, burst, i), atag,
                    beat_addr, exp_addr(a, len, size, burst, i));
                chk(beat_strb == exp_strb(exp_addr(a, len, size, burst, i), size), "R5",
                    beat_strb, exp_strb(exp_addr(a, len, size, burst, i), size));
                chk(beat_last == (i == len), "R1 last", beat_last, (i == len));
                @(posedge clk);
                @(negedge clk);
                if (rdy) i++;
            end
            beat_ready = 1'b0;
            chk(beat_valid == 1'b0, "R1 end of burst", beat_valid, 0);
        end
    endtask

    initial begin
        int lens [7]  = '{0, 1, 3, 4, 7, 15, 255};
        logic [31:0] addrs [4] = '{32'h0, 32'h7, 32'h22, 32'hFF0};
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
        chk(beat_valid == 1'b0, "R10 valid", beat_valid, 0);
        chk(req_err == 1'b0, "R10 err", req_err, 0);
        rst_n = 1'b1;
        // R3 worked case: 4-byte beats from address 7
        run_req(32'h7, 4, 2, 1);
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 4; s++)
                for (int l = 0; l < 7; l++)
                    for (int x = 0; x < 4; x++)
                        run_req(addrs[x], lens[l], s, b);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule